// File: doc/BRIEF.md
# Triplicated System Status Syndrome Register

This block is a 32-bit word that records the health of four memory modules and steers their configuration and power. One part of the word holds per-module power enables and two memory-mode bits, which a downstream memory reconfiguration controller consumes directly. Another part holds a per-module state code plus one sticky fault flag per module. Checking logic elsewhere in the chip reports malfunctions on `fault_in`. Software reads the word and rewrites it through a single-cycle write port.

Because the whole system depends on this word, it is held as three identical copies. A bitwise two-of-three vote forms the only value anyone sees. Each clock, every copy is reloaded from the next value computed from the vote, so a copy disturbed by an upset is repaired one clock later. A disagreement among copies is flagged on `copy_err` while it lasts. An interrupt stays raised while any fault flag is set. The `upset_en`/`upset_mask` inputs model single-event upsets by inverting bits of chosen copies at a clock edge.

Top module: `status_syndrome_reg`

## Requirements
- R1: After a synchronous active-high reset, `rd_data` reads 0x00000081: module 0 powered with state code ideal (2), modules 1 to 3 unpowered with state code off (0), 16-bit and linear modes, and no flags. `irq` and `copy_err` are low.
- R2: Field layout. Bits [3:0] are the power enables for modules 0 to 3 (1 = powered). Bit 4 selects 32-bit addressing when 1 and 16-bit when 0. Bit 5 selects redundant bank use when 1 and linear when 0. Bits [6+3i+2:6+3i] hold module i's state, coded off=0, stand-by=1, ideal=2, failed=3, faulty=4. Bits [21:18] are the sticky fault flags for modules 0 to 3. `mod_power`, `cfg_wide` and `cfg_redundant` always equal bits [3:0], 4 and 5 of `rd_data`.
- R3: A write (`wr_en`=1) loads `wr_data[17:0]` into bits [17:0] of all three copies, taking effect at the next clock.
- R4: If `fault_in[i]` is high while module i is in state ideal, then after the next clock module i is in state failed, flag i is set and `irq` is high.
- R5: A fault report for a module in any state other than ideal is ignored: its state, its flag and `irq` are unchanged.
- R6: `irq` is high exactly while any flag is set. Writing 1 to a flag bit clears that flag. Writing 0 to a flag bit leaves it unchanged. A fault event for a module in the same cycle as a clear of its flag leaves the flag set.
- R7: An upset that inverts bits of a single copy never changes `rd_data`. The same inversion applied to two copies does change `rd_data`.
- R8: A copy that differs from the voted value is overwritten with it at the next clock. `copy_err` is high exactly in the cycles when the copies disagree, so a single upset raises it for one cycle.
- R9: Bits [31:22] of `rd_data` read 0 one clock after any edge without an upset.
- R10: When a write and a qualifying fault event for the same module occur together, the fault event wins for that module: its state becomes failed and its flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 32 | Write data: bits [17:0] loaded, bits [21:18] write-1-to-clear |
| fault_in | input | 4 | Per-module malfunction reports from checking logic |
| upset_en | input | 3 | Selects the copies to be disturbed at this edge |
| upset_mask | input | 32 | Bits inverted in the selected copies |
| rd_data | output | 32 | Voted register value |
| mod_power | output | 4 | Module power enables |
| cfg_wide | output | 1 | 32-bit addressing selected |
| cfg_redundant | output | 1 | Redundant bank use selected |
| irq | output | 1 | Interrupt, high while any fault flag is set |
| copy_err | output | 1 | The three copies disagree |

## Verification
The fault response is swept over every module in each of the five state codes. Only the ideal state may produce a failed state and a flag, which separates state-qualified detection from unconditional latching. Single-bit upsets are walked across all 32 bits of each copy in turn: a correct vote hides every one, while a design that reads one copy or votes wrongly exposes it. A two-copy upset shows that the vote really tracks a majority. Combined cases cover a write colliding with a fault, a flag clear colliding with a new event, and selective flag clearing. Together they pin down the order of priority in the next-value logic.

// File: rtl/syn_pkg.sv
package syn_pkg;

    localparam int WORD_W   = 32;
    localparam int NUM_MOD  = 4;
    localparam int STATE_W  = 3;
    localparam int NUM_COPY = 3;
    localparam int CFG_LSB  = NUM_MOD;                       // bit mode position
    localparam int ST_LSB   = NUM_MOD + 2;                   // first state field
    localparam int FLG_LSB  = ST_LSB + NUM_MOD * STATE_W;    // first flag bit
    localparam int LIVE_W   = FLG_LSB + NUM_MOD;             // used bits
    localparam int RSV_W    = WORD_W - LIVE_W;

    typedef enum logic [STATE_W-1:0] {
        ST_OFF     = 3'd0,
        ST_STANDBY = 3'd1,
        ST_IDEAL   = 3'd2,
        ST_FAILED  = 3'd3,
        ST_FAULTY  = 3'd4
    } mod_state_e;

    typedef struct packed {
        logic [RSV_W-1:0]   rsvd;
        logic [NUM_MOD-1:0] flag;
        logic [NUM_MOD-1:0][STATE_W-1:0] state;
        logic               redundant;
        logic               wide;
        logic [NUM_MOD-1:0] power;
    } syn_word_t;

    function automatic syn_word_t reset_word();
        syn_word_t w;
        w = '0;
        w.power[0] = 1'b1;
        for (int i = 0; i < NUM_MOD; i++) begin
            w.state[i] = (i == 0) ? ST_IDEAL : ST_OFF;
        end
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] majority3(
        logic [WORD_W-1:0] a, logic [WORD_W-1:0] b, logic [WORD_W-1:0] c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/syn_voter.sv
module syn_voter
    import syn_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic [NUM_COPY-1:0][W-1:0] copies,
    output logic [W-1:0]               voted,
    output logic                       mismatch
);
    always_comb begin
        voted    = majority3(copies[0], copies[1], copies[2]);
        mismatch = (copies[0] != copies[1]) || (copies[1] != copies[2]);
    end
endmodule

// File: rtl/syn_next.sv
module syn_next
    import syn_pkg::*;
(
    input  syn_word_t          cur,
    input  logic               wr_en,
    input  logic [WORD_W-1:0]  wr_data,
    input  logic [NUM_MOD-1:0] fault_in,
    output syn_word_t          nxt
);
    syn_word_t wr_w;
    assign wr_w = syn_word_t'(wr_data);

    always_comb begin
        nxt      = cur;
        nxt.rsvd = '0;
        if (wr_en) begin
            nxt.power     = wr_w.power;
            nxt.wide      = wr_w.wide;
            nxt.redundant = wr_w.redundant;
            nxt.state     = wr_w.state;
            nxt.flag      = cur.flag & ~wr_w.flag;
        end
        for (int i = 0; i < NUM_MOD; i++) begin
            if (fault_in[i] && (cur.state[i] == ST_IDEAL)) begin
                nxt.state[i] = ST_FAILED;
                nxt.flag[i]  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/syn_copy_bank.sv
module syn_copy_bank
    import syn_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst,
    input  logic [WORD_W-1:0]                load_val,
    input  logic [NUM_COPY-1:0]              upset_en,
    input  logic [WORD_W-1:0]                upset_mask,
    input  logic                             copy_err,
    output logic [NUM_COPY-1:0][WORD_W-1:0]  copies
);
    localparam logic [WORD_W-1:0] RST_VAL = reset_word();

    for (genvar k = 0; k < NUM_COPY; k++) begin : g_copy
        always_ff @(posedge clk) begin
            if (rst) copies[k] <= RST_VAL;
            else     copies[k] <= load_val ^ (upset_en[k] ? upset_mask : '0);
        end
    end

    // R8: with no upset at an edge, every copy is reloaded and agreement returns
    p_repair_r8: assert property (@(posedge clk) disable iff (rst)
        (copy_err && upset_en == '0) |=> !copy_err);
endmodule

// File: rtl/status_syndrome_reg.sv
module status_syndrome_reg
    import syn_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [WORD_W-1:0]   wr_data,
    input  logic [NUM_MOD-1:0]  fault_in,
    input  logic [NUM_COPY-1:0] upset_en,
    input  logic [WORD_W-1:0]   upset_mask,
    output logic [WORD_W-1:0]   rd_data,
    output logic [NUM_MOD-1:0]  mod_power,
    output logic                cfg_wide,
    output logic                cfg_redundant,
    output logic                irq,
    output logic                copy_err
);
    logic [NUM_COPY-1:0][WORD_W-1:0] copies;
    logic [WORD_W-1:0] voted;
    syn_word_t         cur_w;
    syn_word_t         nxt_w;

    syn_copy_bank u_bank (
        .clk        (clk),
        .rst        (rst),
        .load_val   (nxt_w),
        .upset_en   (upset_en),
        .upset_mask (upset_mask),
        .copy_err   (copy_err),
        .copies     (copies)
    );

    syn_voter #(.W(WORD_W)) u_vote (
        .copies   (copies),
        .voted    (voted),
        .mismatch (copy_err)
    );

    assign cur_w = syn_word_t'(voted);

    syn_next u_next (
        .cur      (cur_w),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .fault_in (fault_in),
        .nxt      (nxt_w)
    );

    assign rd_data       = voted;
    assign mod_power     = cur_w.power;
    assign cfg_wide      = cur_w.wide;
    assign cfg_redundant = cur_w.redundant;
    assign irq           = |cur_w.flag;

    for (genvar i = 0; i < NUM_MOD; i++) begin : g_chk
        // R4: a report against an ideal module latches failed, flag and irq
        p_fault_latch_r4: assert property (@(posedge clk) disable iff (rst)
            (fault_in[i] && cur_w.state[i] == ST_IDEAL && upset_en == '0)
            |=> (rd_data[ST_LSB + i*STATE_W +: STATE_W] == ST_FAILED)
                && rd_data[FLG_LSB + i] && irq);
        // R5: a report against a non-ideal module leaves its field alone
        p_fault_ignored_r5: assert property (@(posedge clk) disable iff (rst)
            (fault_in[i] && cur_w.state[i] != ST_IDEAL && !wr_en && upset_en == '0)
            |=> $stable(rd_data[ST_LSB + i*STATE_W +: STATE_W]) && $stable(rd_data[FLG_LSB + i]));
    end

    // R6: clearing all flags with no new event drops the interrupt
    p_clear_irq_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[FLG_LSB +: NUM_MOD] == '1 && fault_in == '0 && upset_en == '0)
        |=> !irq);

    // R9: an edge without upset leaves the reserved bits at zero
    p_reserved_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (upset_en == '0) |=> (rd_data[WORD_W-1:LIVE_W] == '0));
endmodule

// File: tb/status_syndrome_reg_tb.sv
`timescale 1ns/1ps
module status_syndrome_reg_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [31:0] wr_data;
    logic [3:0]  fault_in;
    logic [2:0]  upset_en;
    logic [31:0] upset_mask;
    logic [31:0] rd_data;
    logic [3:0]  mod_power;
    logic        cfg_wide, cfg_redundant, irq, copy_err;

    int n_run  = 0;
    int n_fail = 0;
    logic [31:0] exp_w;

    always #2.5 clk = ~clk;

    status_syndrome_reg u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .fault_in(fault_in), .upset_en(upset_en), .upset_mask(upset_mask),
        .rd_data(rd_data), .mod_power(mod_power), .cfg_wide(cfg_wide),
        .cfg_redundant(cfg_redundant), .irq(irq), .copy_err(copy_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model(input logic [31:0] cur, input logic we,
                                          input logic [31:0] wd, input logic [3:0] flt);
        logic [31:0] n;
        n = cur & 32'h003F_FFFF;
        if (we) begin
            n[17:0]  = wd[17:0];
            n[21:18] = cur[21:18] & ~wd[21:18];
        end
        for (int i = 0; i < 4; i++) begin
            if (flt[i] && cur[6+3*i +: 3] == 3'd2) begin
                n[6+3*i +: 3] = 3'd3;
                n[18+i] = 1'b1;
            end
        end
        return n;
    endfunction

    function automatic logic [31:0] cfg_word(input int m, input int s);
        logic [31:0] w;
        w = 32'h0000_003F;                    // all powered, wide, redundant
        for (int i = 0; i < 4; i++) w[6+3*i +: 3] = 3'd1;
        w[6+3*m +: 3] = s[2:0];
        return w;
    endfunction

    task automatic step();
        @(posedge clk); #1;
        wr_en = 0; wr_data = '0; fault_in = '0; upset_en = '0; upset_mask = '0;
    endtask

    task automatic op(input logic we, input logic [31:0] wd, input logic [3:0] flt);
        exp_w = model(exp_w, we, wd, flt);
        wr_en = we; wr_data = wd; fault_in = flt;
        step();
    endtask

    task automatic chk_outs(input string req);
        chk(req, rd_data, exp_w);
        chk({req, " irq"}, {31'd0, irq}, {31'd0, |exp_w[21:18]});
        chk({req, " cfg"}, {26'd0, cfg_redundant, cfg_wide, mod_power}, {26'd0, exp_w[5:0]});
    endtask

    initial begin
        #(200000 * 5);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst = 1; wr_en = 0; wr_data = '0; fault_in = '0; upset_en = '0; upset_mask = '0;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        exp_w = 32'h0000_0081;
        // R1 reset value
        chk("R1", rd_data, 32'h0000_0081);
        chk("R1 irq/copy_err", {30'd0, irq, copy_err}, 32'd0);
        chk_outs("R2 reset fields");

        // R3 write loads the configuration; reserved and flag bits ignored on write
        op(1, 32'hFFC0_0A5A, 4'h0);
        chk_outs("R3 write");
        chk("R9 reserved after write", {22'd0, rd_data[31:22]}, 32'd0);
        op(1, 32'h0000_0081, 4'h0);
        chk_outs("R3 rewrite");

        // R4/R5 sweep: every module in every state code, fault reported
        for (int m = 0; m < 4; m++) begin
            for (int s = 0; s < 5; s++) begin
                op(1, cfg_word(m, s), 4'h0);
                chk_outs("R2 state write");
                op(0, '0, 4'h1 << m);
                chk_outs(s == 2 ? "R4 fault on ideal" : "R5 fault ignored");
                op(1, cfg_word(m, s) | 32'h003C_0000, 4'h0);
                chk_outs("R6 clear flags");
            end
        end

        // R4 several modules at once, then selective clear (R6)
        op(1, 32'h0001_248F, 4'h0);       // all four ideal, all powered
        op(0, '0, 4'b0101);
        chk_outs("R4 multi fault");
        op(1, rd_data & 32'h0003_FFFF | 32'h0004_0000, 4'h0); // clear flag 0 only
        chk_outs("R6 selective clear");
        chk("R6 flag2 kept", {31'd0, rd_data[20]}, 32'd1);
        // R6 clear collides with new event on module 1 (ideal)
        op(1, rd_data & 32'h0003_FFFF | 32'h003C_0000, 4'b0010);
        chk_outs("R6 clear vs event");
        chk("R6 flag1 wins", {31'd0, rd_data[19]}, 32'd1);
        // R10 write sets module 3 ideal while its fault arrives: prior state ideal -> failed
        op(1, 32'h0001_248F | 32'h003C_0000, 4'b1000);
        chk_outs("R10 write vs fault");
        chk("R10 state3", {29'd0, rd_data[17:15]}, 32'd3);
        op(1, 32'h003C_0081, 4'h0);
        chk_outs("R6 all clear");

        // R7/R8 single-bit upset walk over each copy
        for (int k = 0; k < 3; k++) begin
            for (int b = 0; b < 32; b++) begin
                upset_en = 3'b001 << k; upset_mask = 32'd1 << b;
                step();
                chk("R7 single copy hidden", rd_data, exp_w);
                chk("R8 copy_err raised", {31'd0, copy_err}, 32'd1);
                step();
                chk("R8 repaired", {31'd0, copy_err}, 32'd0);
                chk("R7 value held", rd_data, exp_w);
            end
        end

        // R7 two-copy upset changes the vote
        upset_en = 3'b011; upset_mask = 32'h0000_0002;
        step();
        exp_w = exp_w ^ 32'h0000_0002;
        chk("R7 two copies visible", rd_data, exp_w);
        chk("R8 copy_err two", {31'd0, copy_err}, 32'd1);
        step();
        chk("R8 third copy repaired", {31'd0, copy_err}, 32'd0);
        chk_outs("R2 power follows vote");

        // R9 reserved bits upset in two copies are cleared on the next edge
        upset_en = 3'b110; upset_mask = 32'h8000_0000;
        step();
        chk("R9 reserved visible", rd_data, exp_w | 32'h8000_0000);
        step();
        chk("R9 reserved cleared", rd_data, exp_w);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule